// File: doc/BRIEF.md
# SIMT Warp Scheduler with Divergence Stack

This block holds the control state of a small SIMT core. For each warp it keeps an active bit, a stall bit, a program counter and a thread mask. Each warp also has a reconvergence stack of saved thread masks.

Every cycle the block offers at most one eligible warp to instruction fetch. A warp is eligible when it is active and not stalled. Warps are picked in round-robin order. When fetch accepts a warp, that warp's PC moves to the next instruction.

Decode reports control-flow instructions, and the block stalls the warp that issued them. Execute then sends back one command, and the command resolves the stall. Commands cover these actions:
- redirect to a new PC,
- set the thread count,
- spawn warps,
- diverge and reconverge,
- wait at a named barrier.

Top module: `warp_sched`

## Requirements
- R1: After reset only warp 0 is active. Its thread mask is 0001 (thread 0 only) and its PC is START_PC. No warp is stalled, no overflow flag is set, and fetch offers warp 0.
- R2: `fetch_valid` is high only when some warp is active and unstalled. The offered warp is such a warp, and `fetch_pc` and `fetch_tmask` are that warp's values. When `fetch_ack` is high with `fetch_valid`, the offered warp's PC grows by 4 at the next edge.
- R3: The offered warp is the first eligible warp found by searching upward, with wraparound, from one position after the last accepted warp. After reset that search starts at warp 0.
- R4: A decode notification (`dec_valid`) stalls warp `dec_wid` from the next cycle on. Command code 1 (resume) sets the warp's PC to `cmd_pc` and clears the stall.
- R5: Command code 2 (thread count N) sets the warp's mask to its lowest N threads. If N exceeds the thread count, all threads become active. If N is 0, the warp is deactivated. The command also clears the warp's stall.
- R6: Command code 3 (spawn N at `cmd_pc`) acts on every inactive warp whose index is below N and which is not the issuing warp. Each such warp becomes active with PC `cmd_pc` and mask 0001. Warps that are already active keep their state.
- R7: Command code 4 (split with predicate P) on a stack that is not full does two things. It pushes (mask AND NOT P) onto the warp's stack, and it sets the warp's mask to (mask AND P).
- R8: Command code 5 (join) pops the warp's stack and restores the popped mask. On an empty stack, join leaves the mask unchanged.
- R9: A split on a full stack sets that warp's `stack_ovf` bit and leaves the mask and the stack unchanged. Once set, the bit stays set until reset.
- R10: Command code 6 (barrier id B, count C) stalls the issuing warp. When the arrivals at B reach C, every warp waiting at B is released in the same cycle. The warp that completes the count is never stalled, so a count of 1 does not stall at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | output | 1 | An eligible warp is offered |
| fetch_wid | output | WID_W | Offered warp index |
| fetch_pc | output | PC_W | Offered warp PC |
| fetch_tmask | output | NUM_THREADS | Offered warp thread mask |
| fetch_ack | input | 1 | Fetch accepts the offered warp |
| dec_valid | input | 1 | Decode saw a control instruction |
| dec_wid | input | WID_W | Warp of the decoded instruction |
| cmd_valid | input | 1 | Command from execute is valid |
| cmd_wid | input | WID_W | Warp issuing the command |
| cmd_op | input | 3 | Command code (1 to 6) |
| cmd_count | input | CNT_W | Thread, warp or barrier count |
| cmd_pc | input | PC_W | Target PC for resume and spawn |
| cmd_pred | input | NUM_THREADS | Split predicate |
| cmd_bar | input | BID_W | Barrier id |
| warp_active | output | NUM_WARPS | Active bit per warp |
| warp_stalled | output | NUM_WARPS | Stall bit per warp (decode or barrier) |
| stack_ovf | output | NUM_WARPS | Sticky stack overflow per warp |

## Verification
Every command, decode notification and fetch acceptance is registered at one rising edge. Its effect on the warp state is therefore visible from that edge onward. The fetch outputs are combinational from that state, so the next offer reflects the update in the same cycle, after one register stage. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and samples every output at that point, exactly one register stage later. For the round-robin order, the bench holds `fetch_ack` and reads the offered warp at each falling edge before the edge that accepts it.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_RESUME = 3'd1,
      OP_TMC    = 3'd2,
      OP_SPAWN  = 3'd3,
      OP_SPLIT  = 3'd4,
      OP_JOIN   = 3'd5,
      OP_BAR    = 3'd6
   } sched_op_e;
endpackage

// File: rtl/warp_rr_pick.sv
module warp_rr_pick #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   input  logic [IW-1:0] last,
   output logic          any,
   output logic [IW-1:0] idx
);
   // search starts one slot after the last accepted warp
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int k = 1; k <= N; k++) begin
         int c;
         c = (int'(last) + k) % N;
         if (!any && req[c]) begin
            any = 1'b1;
            idx = IW'(c);
         end
      end
   end
endmodule

// File: rtl/warp_recon_stack.sv
module warp_recon_stack #(
   parameter int W     = 4,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PTR_W = $clog2(DEPTH + 1);
   localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] cnt;

   assign empty = (cnt == '0);
   assign full  = (cnt == PTR_W'(DEPTH));

   generate
      if (DEPTH == 1) begin : g_single
         assign dout = empty ? '0 : mem[0];
      end else begin : g_multi
         logic [AW-1:0] top_idx;
         assign top_idx = AW'(cnt - 1'b1);
         assign dout    = empty ? '0 : mem[top_idx];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (push && !full) begin
         mem[AW'(cnt)] <= din;
         cnt           <= cnt + 1'b1;
      end else if (pop && !empty) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/warp_barrier.sv
module warp_barrier #(
   parameter int NW    = 4,
   parameter int NB    = 4,
   parameter int CNT_W = 3,
   parameter int WID_W = 2,
   parameter int BID_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arrive,
   input  logic [WID_W-1:0] arr_wid,
   input  logic [BID_W-1:0] arr_id,
   input  logic [CNT_W-1:0] arr_count,
   output logic [NW-1:0]    wait_vec
);
   logic [CNT_W-1:0] arrived [NB];
   logic [BID_W-1:0] bar_of  [NW];
   logic [NW-1:0]    wait_q;
   logic             complete;

   assign complete = ({1'b0, arrived[arr_id]} + 1'b1) >= {1'b0, arr_count};
   assign wait_vec = wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wait_q <= '0;
         for (int b = 0; b < NB; b++) arrived[b] <= '0;
         for (int w = 0; w < NW; w++) bar_of[w] <= '0;
      end else if (arrive) begin
         if (complete) begin
            arrived[arr_id] <= '0;
            for (int w = 0; w < NW; w++)
               if (wait_q[w] && bar_of[w] == arr_id) wait_q[w] <= 1'b0;
         end else begin
            arrived[arr_id]  <= arrived[arr_id] + 1'b1;
            wait_q[arr_wid]  <= 1'b1;
            bar_of[arr_wid]  <= arr_id;
         end
      end
   end
endmodule

// File: rtl/warp_sched.sv
module warp_sched
   import warp_sched_pkg::*;
#(
   parameter int             NUM_WARPS   = 4,
   parameter int             NUM_THREADS = 4,
   parameter int             PC_W        = 32,
   parameter int             STACK_DEPTH = 2,
   parameter int             NUM_BARS    = 4,
   parameter logic [31:0]    START_PC    = 32'h0000_0100,
   localparam int            WID_W       = $clog2(NUM_WARPS),
   localparam int            BID_W       = $clog2(NUM_BARS),
   localparam int            CNT_MAX     = (NUM_WARPS > NUM_THREADS) ? NUM_WARPS : NUM_THREADS,
   localparam int            CNT_W       = $clog2(CNT_MAX + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   output logic                   fetch_valid,
   output logic [WID_W-1:0]       fetch_wid,
   output logic [PC_W-1:0]        fetch_pc,
   output logic [NUM_THREADS-1:0] fetch_tmask,
   input  logic                   fetch_ack,
   input  logic                   dec_valid,
   input  logic [WID_W-1:0]       dec_wid,
   input  logic                   cmd_valid,
   input  logic [WID_W-1:0]       cmd_wid,
   input  logic [2:0]             cmd_op,
   input  logic [CNT_W-1:0]       cmd_count,
   input  logic [PC_W-1:0]        cmd_pc,
   input  logic [NUM_THREADS-1:0] cmd_pred,
   input  logic [BID_W-1:0]       cmd_bar,
   output logic [NUM_WARPS-1:0]   warp_active,
   output logic [NUM_WARPS-1:0]   warp_stalled,
   output logic [NUM_WARPS-1:0]   stack_ovf
);
   initial begin
      assert (NUM_WARPS >= 2)   else $error("NUM_WARPS must be at least 2");
      assert (NUM_THREADS >= 1) else $error("NUM_THREADS must be at least 1");
      assert (STACK_DEPTH >= 1) else $error("STACK_DEPTH must be at least 1");
      assert (NUM_BARS >= 2)    else $error("NUM_BARS must be at least 2");
      assert (PC_W >= 3)        else $error("PC_W too narrow");
   end

   logic [NUM_WARPS-1:0]                  dstall;
   logic [NUM_WARPS-1:0]                  bar_wait;
   logic [NUM_WARPS-1:0][NUM_THREADS-1:0] tmask_q;
   logic [PC_W-1:0]                       pc_a [NUM_WARPS];
   logic [WID_W-1:0]                      last_q;
   logic [NUM_THREADS-1:0]                tmc_mask;
   logic                                  accept;
   logic                                  bar_arrive;

   assign warp_stalled = dstall | bar_wait;
   assign accept       = fetch_valid && fetch_ack;
   assign bar_arrive   = cmd_valid && (cmd_op == OP_BAR);

   // lowest cmd_count threads
   always_comb begin
      for (int t = 0; t < NUM_THREADS; t++)
         tmc_mask[t] = (CNT_W'(t) < cmd_count);
   end

   warp_rr_pick #(.N(NUM_WARPS), .IW(WID_W)) u_pick (
      .req  (warp_active & ~warp_stalled),
      .last (last_q),
      .any  (fetch_valid),
      .idx  (fetch_wid)
   );

   assign fetch_pc    = pc_a[fetch_wid];
   assign fetch_tmask = tmask_q[fetch_wid];

   always_ff @(posedge clk) begin
      if (!rst_n)      last_q <= WID_W'(NUM_WARPS - 1);
      else if (accept) last_q <= fetch_wid;
   end

   warp_barrier #(
      .NW(NUM_WARPS), .NB(NUM_BARS), .CNT_W(CNT_W), .WID_W(WID_W), .BID_W(BID_W)
   ) u_bar (
      .clk       (clk),
      .rst_n     (rst_n),
      .arrive    (bar_arrive),
      .arr_wid   (cmd_wid),
      .arr_id    (cmd_bar),
      .arr_count (cmd_count),
      .wait_vec  (bar_wait)
   );

   generate
      for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
         logic                   act_r, stall_r, ovf_r;
         logic [PC_W-1:0]        pc_r;
         logic [NUM_THREADS-1:0] mask_r;
         logic                   is_cmd, spawn_hit, stk_push, stk_pop;
         logic [NUM_THREADS-1:0] stk_top;
         logic                   stk_empty, stk_full;

         assign is_cmd    = cmd_valid && (cmd_wid == WID_W'(w));
         assign spawn_hit = cmd_valid && (cmd_op == OP_SPAWN) && !is_cmd &&
                            (CNT_W'(w) < cmd_count) && !act_r;
         assign stk_push  = is_cmd && (cmd_op == OP_SPLIT);
         assign stk_pop   = is_cmd && (cmd_op == OP_JOIN);

         warp_recon_stack #(.W(NUM_THREADS), .DEPTH(STACK_DEPTH)) u_stk (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (stk_push),
            .pop   (stk_pop),
            .din   (mask_r & ~cmd_pred),
            .dout  (stk_top),
            .empty (stk_empty),
            .full  (stk_full)
         );

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               act_r   <= (w == 0);
               stall_r <= 1'b0;
               ovf_r   <= 1'b0;
               pc_r    <= PC_W'(START_PC);
               mask_r  <= (w == 0) ? NUM_THREADS'(1) : '0;
            end else begin
               if (accept && fetch_wid == WID_W'(w)) pc_r <= pc_r + PC_W'(4);
               if (dec_valid && dec_wid == WID_W'(w)) stall_r <= 1'b1;
               if (spawn_hit) begin
                  act_r  <= 1'b1;
                  pc_r   <= cmd_pc;
                  mask_r <= NUM_THREADS'(1);
               end
               if (is_cmd) begin
                  stall_r <= 1'b0;
                  case (cmd_op)
                     OP_RESUME: pc_r <= cmd_pc;
                     OP_TMC: begin
                        mask_r <= tmc_mask;
                        if (tmc_mask == '0) act_r <= 1'b0;
                     end
                     OP_SPLIT: begin
                        if (stk_full) ovf_r  <= 1'b1;
                        else          mask_r <= mask_r & cmd_pred;
                     end
                     OP_JOIN: begin
                        if (!stk_empty) mask_r <= stk_top;
                     end
                     default: ;
                  endcase
               end
            end
         end

         assign warp_active[w] = act_r;
         assign dstall[w]      = stall_r;
         assign stack_ovf[w]   = ovf_r;
         assign pc_a[w]        = pc_r;
         assign tmask_q[w]     = mask_r;
      end
   endgenerate
endmodule

// File: rtl/warp_sched_chk.sv
module warp_sched_chk
   import warp_sched_pkg::*;
#(
   parameter int NW    = 4,
   parameter int NT    = 4,
   parameter int WID_W = 2,
   parameter int CNT_W = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   fetch_valid,
   input logic [WID_W-1:0]       fetch_wid,
   input logic                   dec_valid,
   input logic [WID_W-1:0]       dec_wid,
   input logic                   cmd_valid,
   input logic [WID_W-1:0]       cmd_wid,
   input logic [2:0]             cmd_op,
   input logic [CNT_W-1:0]       cmd_count,
   input logic [NW-1:0]          warp_active,
   input logic [NW-1:0]          warp_stalled,
   input logic [NW-1:0]          stack_ovf,
   input logic [NW-1:0][NT-1:0]  tmask
);
   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (warp_active == NW'(1) && warp_stalled == '0 && stack_ovf == '0));

   // R2
   offer_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_valid |-> (warp_active[fetch_wid] && !warp_stalled[fetch_wid]));

   // R4
   decode_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && !(cmd_valid && cmd_wid == dec_wid)) |=> warp_stalled[$past(dec_wid)]);

   // R5
   tmc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_TMC && cmd_count != '0 && int'(cmd_count) <= NT)
      |=> ($countones(tmask[$past(cmd_wid)]) == int'($past(cmd_count))));

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((stack_ovf & $past(stack_ovf)) == $past(stack_ovf)));
endmodule

bind warp_sched warp_sched_chk #(
   .NW(NUM_WARPS), .NT(NUM_THREADS), .WID_W(WID_W), .CNT_W(CNT_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_valid  (fetch_valid),
   .fetch_wid    (fetch_wid),
   .dec_valid    (dec_valid),
   .dec_wid      (dec_wid),
   .cmd_valid    (cmd_valid),
   .cmd_wid      (cmd_wid),
   .cmd_op       (cmd_op),
   .cmd_count    (cmd_count),
   .warp_active  (warp_active),
   .warp_stalled (warp_stalled),
   .stack_ovf    (stack_ovf),
   .tmask        (tmask_q)
);

// File: tb/tb_warp_sched.sv
module tb_warp_sched;
   localparam logic [2:0] RESUME = 3'd1, TMC = 3'd2, SPAWN = 3'd3,
                          SPLIT = 3'd4, JOIN = 3'd5, BAR = 3'd6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_valid, fetch_ack = 1'b0;
   logic [1:0]  fetch_wid;
   logic [31:0] fetch_pc;
   logic [3:0]  fetch_tmask;
   logic        dec_valid = 1'b0;
   logic [1:0]  dec_wid = '0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_wid = '0;
   logic [2:0]  cmd_op = '0;
   logic [2:0]  cmd_count = '0;
   logic [31:0] cmd_pc = '0;
   logic [3:0]  cmd_pred = '0;
   logic [1:0]  cmd_bar = '0;
   logic [3:0]  warp_active, warp_stalled, stack_ovf;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   warp_sched dut (
      .clk(clk), .rst_n(rst_n),
      .fetch_valid(fetch_valid), .fetch_wid(fetch_wid), .fetch_pc(fetch_pc),
      .fetch_tmask(fetch_tmask), .fetch_ack(fetch_ack),
      .dec_valid(dec_valid), .dec_wid(dec_wid),
      .cmd_valid(cmd_valid), .cmd_wid(cmd_wid), .cmd_op(cmd_op),
      .cmd_count(cmd_count), .cmd_pc(cmd_pc), .cmd_pred(cmd_pred), .cmd_bar(cmd_bar),
      .warp_active(warp_active), .warp_stalled(warp_stalled), .stack_ovf(stack_ovf)
   );

   // {count, expected mask} for thread count commands on warp 0
   localparam logic [6:0] TMC_TAB [5] = '{
      {3'd4, 4'b1111}, {3'd2, 4'b0011}, {3'd6, 4'b1111}, {3'd3, 4'b0111}, {3'd1, 4'b0001}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] w, input logic [2:0] op, input logic [2:0] n,
                       input logic [31:0] pc, input logic [3:0] pred, input logic [1:0] b);
      cmd_valid = 1'b1; cmd_wid = w; cmd_op = op; cmd_count = n;
      cmd_pc = pc; cmd_pred = pred; cmd_bar = b;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 active", 32'(warp_active), 32'h1);
      chk("R1 offer", {fetch_valid, 29'd0, fetch_wid}, {1'b1, 31'd0});
      chk("R1 pc", fetch_pc, 32'h100);
      chk("R1 mask", 32'(fetch_tmask), 32'h1);
      chk("R1 stall/ovf", {warp_stalled, stack_ovf}, 32'h0);

      // R2 accept advances PC
      fetch_ack = 1'b1; @(negedge clk); fetch_ack = 1'b0;
      chk("R2 pc step", fetch_pc, 32'h104);

      // R5 table walk
      for (int i = 0; i < 5; i++) begin
         send(2'd0, TMC, TMC_TAB[i][6:4], '0, '0, '0);
         chk("R5 tmc mask", 32'(fetch_tmask), 32'(TMC_TAB[i][3:0]));
      end

      // R4 decode stall and resume
      dec_valid = 1'b1; dec_wid = 2'd0; @(negedge clk); dec_valid = 1'b0;
      chk("R4 stalled", {31'd0, fetch_valid}, 32'h0);
      chk("R4 stall bit", 32'(warp_stalled), 32'h1);
      send(2'd0, RESUME, '0, 32'h200, '0, '0);
      chk("R4 resume pc", {fetch_valid, fetch_pc[30:0]}, {1'b1, 31'h200});

      // R6 spawn
      send(2'd0, SPAWN, 3'd3, 32'h300, '0, '0);
      chk("R6 active", 32'(warp_active), 32'h7);

      // R3 round robin: last accepted was 0
      fetch_ack = 1'b1;
      for (int i = 0; i < 3; i++) begin
         logic [1:0] exp_w;
         exp_w = (i == 0) ? 2'd1 : (i == 1) ? 2'd2 : 2'd0;
         chk("R3 order", 32'(fetch_wid), 32'(exp_w));
         if (i == 0) chk("R6 spawn mask/pc", {fetch_tmask, fetch_pc[27:0]}, {4'b0001, 28'h300});
         @(negedge clk);
      end
      fetch_ack = 1'b0;
      chk("R2 warp1 pc", {30'd0, fetch_wid}, 32'h1);
      chk("R2 warp1 pc value", fetch_pc, 32'h304);

      // R2 stalled warp skipped
      dec_valid = 1'b1; dec_wid = 2'd1; @(negedge clk); dec_valid = 1'b0;
      chk("R2 skip stalled", 32'(fetch_wid), 32'h2);

      // R5 zero count deactivates
      send(2'd2, TMC, 3'd0, '0, '0, '0);
      chk("R5 deactivate", 32'(warp_active), 32'h3);
      send(2'd1, TMC, 3'd0, '0, '0, '0);
      chk("R5 deactivate 2", {warp_active, warp_stalled}, {24'd0, 4'h1, 4'h0});
      send(2'd0, TMC, 3'd4, '0, '0, '0);

      // R7 R8 R9 divergence stack (depth 2)
      send(2'd0, SPLIT, '0, '0, 4'b0101, '0);
      chk("R7 split 1", 32'(fetch_tmask), 32'h5);
      send(2'd0, SPLIT, '0, '0, 4'b0001, '0);
      chk("R7 split 2", 32'(fetch_tmask), 32'h1);
      send(2'd0, SPLIT, '0, '0, 4'b0000, '0);
      chk("R9 overflow mask", 32'(fetch_tmask), 32'h1);
      chk("R9 overflow flag", 32'(stack_ovf), 32'h1);
      send(2'd0, JOIN, '0, '0, '0, '0);
      chk("R8 join 1", 32'(fetch_tmask), 32'h4);
      send(2'd0, JOIN, '0, '0, '0, '0);
      chk("R8 join 2", 32'(fetch_tmask), 32'hA);
      send(2'd0, JOIN, '0, '0, '0, '0);
      chk("R8 join empty", 32'(fetch_tmask), 32'hA);
      chk("R9 sticky", 32'(stack_ovf), 32'h1);

      // R10 barrier
      send(2'd0, SPAWN, 3'd3, 32'h400, '0, '0);
      send(2'd0, BAR, 3'd3, '0, '0, 2'd1);
      chk("R10 first arrival", 32'(warp_stalled), 32'h1);
      send(2'd1, BAR, 3'd3, '0, '0, 2'd1);
      chk("R10 second arrival", 32'(warp_stalled), 32'h3);
      chk("R10 offer waiting-free", 32'(fetch_wid), 32'h2);
      send(2'd2, BAR, 3'd3, '0, '0, 2'd1);
      chk("R10 release", {warp_active, warp_stalled}, {24'd0, 4'h7, 4'h0});
      send(2'd0, BAR, 3'd1, '0, '0, 2'd2);
      chk("R10 count one", 32'(warp_stalled), 32'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule